// File: doc/BRIEF.md
# Zero Common-Mode Carrier Modulator for a Three-Level Phase Leg Set

This block drives the three phase legs of a three-level neutral-clamped inverter. It uses only switching states in which the three phase levels cancel, which are the all-neutral state and the six states where one phase sits at the positive rail, one sits at the negative rail and one sits at neutral. With these states only, the ideal common-mode voltage at the load star point is zero.

Three signed phase references are held for a whole carrier period. Each one is shifted by the same zero-sequence offset and clamped. Each is then turned into a threshold and compared with one shared up/down triangular counter, which gives one binary comparison bit per phase. The level of each phase is the difference of its own bit and the bit of the next phase. That level is encoded as a three-state value and expanded into four gate commands for the leg. The carrier half period is an input that is sampled once per period, so a controller that varies the switching period from one period to the next can drive it. A one-cycle sync pulse at the carrier peak tells that controller when its references and period are taken.

Top module: `zcm_modulator`

## Requirements
- R1: While rstN is low, and after it is released until the first carrier peak, every phase level is neutral (2'b00), gates equals 12'h666 and periodSync is low.
- R2: The carrier counts 0,1,…,H,H-1,…,1 and repeats, so one period lasts 2H clocks. H is the sampled halfPeriod, and a value of 0 is treated as 1. periodSync is high for exactly the one clock in which the carrier is at its peak.
- R3: refA, refB, refC and halfPeriod are taken only on the rising edge that ends a periodSync cycle. A change to them at any other time has no effect on the outputs until that edge.
- R4: Each taken reference is shifted by z = -floor((max+min)/2), where max and min are over the three references. The result is clamped to [-2^(REF_W-1), 2^(REF_W-1)-1].
- R5: With the clamped value s and the sampled H, the threshold is t = ((s + 2^(REF_W-1)) * H) >> REF_W. The comparison bit of the phase is registered and is 1 in the cycle after a cycle whose carrier value is below t.
- R6: Phase A level = bitA - bitB, phase B level = bitB - bitC, phase C level = bitC - bitA. A level is encoded on two bits as 2'b01 for +1 (positive rail), 2'b00 for neutral and 2'b11 for -1 (negative rail).
- R7: Each phase has four gates in gates[4i+3:4i] (A is i=0, B is i=1, C is i=2), with bit 3 the upper outer switch. The patterns are 4'b1100 for +1, 4'b0110 for neutral and 4'b0011 for -1, and no other pattern ever appears.
- R8: The signed sum of the three phase levels is zero in every cycle.
- R9: No phase level goes from +1 to -1, or from -1 to +1, in one clock.
- R10: When the three thresholds are distinct and lie in 1..H-1, each phase level changes exactly four times per carrier period.
- R11: When the three references are equal, every phase stays neutral for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refA | input | REF_W | Phase A reference, signed two's complement |
| refB | input | REF_W | Phase B reference, signed two's complement |
| refC | input | REF_W | Phase C reference, signed two's complement |
| halfPeriod | input | CNT_W | Carrier half period in clocks (0 acts as 1) |
| lvlA | output | 2 | Phase A level code |
| lvlB | output | 2 | Phase B level code |
| lvlC | output | 2 | Phase C level code |
| gates | output | 12 | Four gate commands per phase |
| periodSync | output | 1 | High during the carrier-peak clock |

## Verification
The hardest behaviour to show from the ports is that references are held for a whole period and are not followed live. The counter is not visible, so the stimulus locks onto periodSync. It changes the references one clock after the pulse, then shows that the old pattern goes on for the following half period before the new pattern appears. The clamp corner is reached with references at both ends of the signed range, where the zero-sequence shift pushes one phase one step past full scale. The level counts per period then show whether that phase was clamped or wrapped around.

// File: rtl/zcm_pkg.sv
package zcm_pkg;

  // Three-state phase level, encoded as a 2-bit two's complement value.
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } level_e;

  // Strobes from the carrier control to the datapath.
  typedef struct packed {
    logic peak;   // carrier at its top value this cycle
  } carStrobe_t;

  // Gate pattern for one leg; bit 3 is the upper outer switch.
  function automatic logic [3:0] gatePattern(level_e lvl);
    case (lvl)
      LVL_POS: return 4'b1100;
      LVL_NEG: return 4'b0011;
      default: return 4'b0110;
    endcase
  endfunction

  // Level of a phase from its own comparison bit and the next phase's bit.
  function automatic level_e levelOf(logic selfBit, logic nextBit);
    if (selfBit && !nextBit) return LVL_POS;
    if (!selfBit && nextBit) return LVL_NEG;
    return LVL_ZERO;
  endfunction

endpackage

// File: rtl/zcm_carrier_ctrl.sv
module zcm_carrier_ctrl
  import zcm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic [CNT_W-1:0] carrier,
  output logic [CNT_W-1:0] halfCur,
  output carStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             dirUp;
  logic             atPeak;
  logic [CNT_W-1:0] halfReq;

  // A zero request would stall the counter; the smallest usable value is 1.
  assign halfReq     = (halfPeriod == '0) ? ONE : halfPeriod;
  assign atPeak      = dirUp && (carrier >= halfCur);
  assign strobe.peak = atPeak;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier <= '0;
      dirUp   <= 1'b1;
      halfCur <= ONE;
    end else if (atPeak) begin
      halfCur <= halfReq;
      carrier <= carrier - ONE;
      dirUp   <= (carrier == ONE);
    end else if (dirUp) begin
      carrier <= carrier + ONE;
    end else if (carrier == '0) begin
      carrier <= ONE;
      dirUp   <= 1'b1;
    end else begin
      carrier <= carrier - ONE;
      dirUp   <= (carrier == ONE);
    end
  end

endmodule

// File: rtl/zcm_datapath.sv
module zcm_datapath
  import zcm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  carStrobe_t         strobe,
  input  logic [CNT_W-1:0]   carrier,
  input  logic [CNT_W-1:0]   halfCur,
  input  logic [3*REF_W-1:0] refBus,
  output logic [5:0]         lvlBus,
  output logic [11:0]        gateBus
);

  localparam int NPH    = 3;
  localparam int PROD_W = REF_W + CNT_W;
  localparam int EXT_W  = REF_W + 2;

  logic signed [REF_W-1:0] refHeld [NPH];
  logic signed [REF_W-1:0] refMax;
  logic signed [REF_W-1:0] refMin;
  logic signed [REF_W:0]   refSum;
  logic signed [REF_W:0]   refHalf;
  logic signed [REF_W:0]   zeroSeq;
  logic [CNT_W-1:0]        thr [NPH];
  logic [NPH-1:0]          cmpBit;

  // References are held from one carrier peak to the next.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPH; i++) refHeld[i] <= '0;
    end else if (strobe.peak) begin
      for (int i = 0; i < NPH; i++) refHeld[i] <= refBus[i*REF_W +: REF_W];
    end
  end

  // Zero-sequence offset: minus half the sum of the extreme references.
  always_comb begin
    refMax = refHeld[0];
    refMin = refHeld[0];
    for (int i = 1; i < NPH; i++) begin
      if (refHeld[i] > refMax) refMax = refHeld[i];
      if (refHeld[i] < refMin) refMin = refHeld[i];
    end
  end

  assign refSum  = {refMax[REF_W-1], refMax} + {refMin[REF_W-1], refMin};
  assign refHalf = refSum >>> 1;
  assign zeroSeq = -refHalf;

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    logic [EXT_W-1:0]  adj;
    logic [REF_W-1:0]  sat;
    logic [REF_W-1:0]  offs;
    logic [PROD_W-1:0] prod;
    logic              inRange;

    assign adj = {{2{refHeld[i][REF_W-1]}}, refHeld[i]}
               + {zeroSeq[REF_W], zeroSeq};
    // In range when the top three bits agree.
    assign inRange = (adj[EXT_W-1:REF_W-1] == '0) || (adj[EXT_W-1:REF_W-1] == '1);
    assign sat = inRange          ? adj[REF_W-1:0] :
                 adj[EXT_W-1]     ? {1'b1, {(REF_W-1){1'b0}}} :
                                    {1'b0, {(REF_W-1){1'b1}}};
    // Offset binary: adding half scale flips the sign bit.
    assign offs = {~sat[REF_W-1], sat[REF_W-2:0]};
    assign prod = PROD_W'(offs) * PROD_W'(halfCur);
    assign thr[i] = prod[PROD_W-1:REF_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpBit <= '0;
    end else begin
      for (int i = 0; i < NPH; i++) cmpBit[i] <= (carrier < thr[i]);
    end
  end

  for (genvar i = 0; i < NPH; i++) begin : g_out
    localparam int NXT = (i + 1) % NPH;
    level_e lvl;
    assign lvl              = levelOf(cmpBit[i], cmpBit[NXT]);
    assign lvlBus[2*i +: 2] = lvl;
    assign gateBus[4*i +: 4] = gatePattern(lvl);
  end

endmodule

// File: rtl/zcm_modulator.sv
module zcm_modulator
  import zcm_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [REF_W-1:0] refA,
  input  logic signed [REF_W-1:0] refB,
  input  logic signed [REF_W-1:0] refC,
  input  logic [CNT_W-1:0]        halfPeriod,
  output logic [1:0]              lvlA,
  output logic [1:0]              lvlB,
  output logic [1:0]              lvlC,
  output logic [11:0]             gates,
  output logic                    periodSync
);

  carStrobe_t       strobe;
  logic [CNT_W-1:0] carrier;
  logic [CNT_W-1:0] halfCur;
  logic [5:0]       lvlBus;

  zcm_carrier_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .halfPeriod (halfPeriod),
    .carrier    (carrier),
    .halfCur    (halfCur),
    .strobe     (strobe)
  );

  zcm_datapath #(.REF_W(REF_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .carrier (carrier),
    .halfCur (halfCur),
    .refBus  ({refC, refB, refA}),
    .lvlBus  (lvlBus),
    .gateBus (gates)
  );

  assign lvlA       = lvlBus[1:0];
  assign lvlB       = lvlBus[3:2];
  assign lvlC       = lvlBus[5:4];
  assign periodSync = strobe.peak;

endmodule

// File: rtl/zcm_checks.sv
module zcm_checks (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  lvlA,
  input logic [1:0]  lvlB,
  input logic [1:0]  lvlC,
  input logic [11:0] gates,
  input logic        periodSync
);

  logic signed [4:0] levelSum;
  logic [5:0]        lvlAll;

  assign levelSum = 5'($signed({lvlA[1], lvlA})) + 5'($signed({lvlB[1], lvlB}))
                  + 5'($signed({lvlC[1], lvlC}));
  assign lvlAll = {lvlC, lvlB, lvlA};

  AST_LEVEL_SUM_ZERO: assert property (@(posedge clk) disable iff (!rstN) levelSum == 5'sd0); // R8
  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rstN) periodSync |=> !periodSync); // R2

  for (genvar i = 0; i < 3; i++) begin : g_leg
    AST_GATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN) (gates[4*i +: 4] == 4'b1100) || (gates[4*i +: 4] == 4'b0110) || (gates[4*i +: 4] == 4'b0011)); // R7
    AST_NO_POS_TO_NEG: assert property (@(posedge clk) disable iff (!rstN) (lvlAll[2*i +: 2] == 2'b01) |=> (lvlAll[2*i +: 2] != 2'b11)); // R9
    AST_NO_NEG_TO_POS: assert property (@(posedge clk) disable iff (!rstN) (lvlAll[2*i +: 2] == 2'b11) |=> (lvlAll[2*i +: 2] != 2'b01)); // R9
  end

endmodule

bind zcm_modulator zcm_checks u_checks (
  .clk        (clk),
  .rstN       (rstN),
  .lvlA       (lvlA),
  .lvlB       (lvlB),
  .lvlC       (lvlC),
  .gates      (gates),
  .periodSync (periodSync)
);

// File: tb/zcm_modulator_tb.sv
module zcm_modulator_tb;

  localparam int REF_W = 12;
  localparam int CNT_W = 10;
  localparam int FS    = 1 << (REF_W - 1);

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic signed [REF_W-1:0] refA = '0;
  logic signed [REF_W-1:0] refB = '0;
  logic signed [REF_W-1:0] refC = '0;
  logic [CNT_W-1:0]        halfPeriod = CNT_W'(64);
  logic [1:0]              lvlA, lvlB, lvlC;
  logic [11:0]             gates;
  logic                    periodSync;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  zcm_modulator #(.REF_W(REF_W), .CNT_W(CNT_W)) u_dut (
    .clk (clk), .rstN (rstN), .refA (refA), .refB (refB), .refC (refC),
    .halfPeriod (halfPeriod), .lvlA (lvlA), .lvlB (lvlB), .lvlC (lvlC),
    .gates (gates), .periodSync (periodSync)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int dec(logic [1:0] v);
    case (v)
      2'b01: return 1;
      2'b11: return -1;
      2'b00: return 0;
      default: return 99;
    endcase
  endfunction

  function automatic logic [3:0] pat(int l);
    return (l == 1) ? 4'b1100 : (l == -1) ? 4'b0011 : 4'b0110;
  endfunction

  function automatic int below(int t);
    return (t == 0) ? 0 : 2 * t - 1;
  endfunction

  task automatic waitSync();
    @(negedge clk);
    while (periodSync !== 1'b1) @(negedge clk);
  endtask

  task automatic applyInputs(int a, int b, int c, int h);
    refA = REF_W'(a);
    refB = REF_W'(b);
    refC = REF_W'(c);
    halfPeriod = CNT_W'(h);
  endtask

  // R1: reset state
  task automatic tReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check(lvlA == 2'b00 && lvlB == 2'b00 && lvlC == 2'b00, "R1", "levels in reset",
          {lvlC, lvlB, lvlA}, 0);
    check(gates == 12'h666, "R1", "gates in reset", gates, 12'h666);
    check(periodSync == 1'b0, "R1", "sync in reset", periodSync, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(gates == 12'h666, "R1", "gates after release", gates, 12'h666);
  endtask

  // Steady-state window of one period: level counts, transitions, legality.
  task automatic tWindow(string req, int a, int b, int c, int h, int expTrans);
    int s[3], t[3], pos[3], neg[3], trans[3], prev[3], cur[3];
    int mx, mn, zs, hEff;
    bit sumOk, gateOk, swingOk;
    hEff = (h == 0) ? 1 : h;
    applyInputs(a, b, c, h);
    repeat (3) waitSync();
    repeat (3) @(negedge clk);
    s[0] = a; s[1] = b; s[2] = c;
    mx = s[0]; mn = s[0];
    for (int i = 1; i < 3; i++) begin
      if (s[i] > mx) mx = s[i];
      if (s[i] < mn) mn = s[i];
    end
    zs = -((mx + mn) >>> 1);
    for (int i = 0; i < 3; i++) begin
      int v;
      v = s[i] + zs;
      if (v > FS - 1) v = FS - 1;
      if (v < -FS) v = -FS;
      t[i] = ((v + FS) * hEff) >>> REF_W;
      pos[i] = 0; neg[i] = 0; trans[i] = 0;
    end
    prev[0] = dec(lvlA); prev[1] = dec(lvlB); prev[2] = dec(lvlC);
    sumOk = 1'b1; gateOk = 1'b1; swingOk = 1'b1;
    for (int k = 0; k < 2 * hEff; k++) begin
      @(negedge clk);
      cur[0] = dec(lvlA); cur[1] = dec(lvlB); cur[2] = dec(lvlC);
      if (cur[0] + cur[1] + cur[2] != 0) sumOk = 1'b0;
      for (int i = 0; i < 3; i++) begin
        if (gates[4*i +: 4] != pat(cur[i]) || cur[i] == 99) gateOk = 1'b0;
        if (cur[i] * prev[i] == -1) swingOk = 1'b0;
        if (cur[i] != prev[i]) trans[i]++;
        if (cur[i] == 1) pos[i]++;
        if (cur[i] == -1) neg[i]++;
        prev[i] = cur[i];
      end
    end
    for (int i = 0; i < 3; i++) begin
      int d;
      d = below(t[i]) - below(t[(i + 1) % 3]);
      check(pos[i] == ((d > 0) ? d : 0), req, $sformatf("phase %0d +1 cycles (R6)", i),
            pos[i], (d > 0) ? d : 0);
      check(neg[i] == ((d < 0) ? -d : 0), req, $sformatf("phase %0d -1 cycles (R6)", i),
            neg[i], (d < 0) ? -d : 0);
      if (expTrans >= 0)
        check(trans[i] == expTrans, "R10", $sformatf("phase %0d transitions", i),
              trans[i], expTrans);
    end
    check(sumOk, "R8", "level sum zero every cycle", sumOk, 1);
    check(gateOk, "R7", "gate pattern matches level", gateOk, 1);
    check(swingOk, "R9", "no full-swing step", swingOk, 1);
  endtask

  // R2: sync spacing equals 2H
  task automatic tPeriod(int h);
    int n, expN;
    expN = 2 * ((h == 0) ? 1 : h);
    halfPeriod = CNT_W'(h);
    repeat (3) waitSync();
    for (int rep = 0; rep < 2; rep++) begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (periodSync !== 1'b1);
      check(n == expN, "R2", $sformatf("period for H=%0d", h), n, expN);
    end
  endtask

  // R3: a reference change after the peak waits for the next peak
  task automatic tLatch();
    int seenPos;
    applyInputs(1000, 0, -1000, 64);
    repeat (3) waitSync();
    waitSync();
    @(negedge clk);
    applyInputs(0, 0, 0, 64);
    seenPos = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (lvlA == 2'b01) seenPos++;
      if (periodSync === 1'b1) seenPos = -1000;
    end
    check(seenPos > 0, "R3", "old pattern held until next peak", seenPos, 1);
    repeat (2) waitSync();
    repeat (3) @(negedge clk);
    seenPos = 0;
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      if (lvlA != 2'b00 || lvlB != 2'b00 || lvlC != 2'b00) seenPos++;
    end
    check(seenPos == 0, "R3", "new references applied after peak", seenPos, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tPeriod(64);
    tWindow("R11", 300, 300, 300, 64, 0);
    tWindow("R5", 1000, -500, -500, 64, -1);
    tWindow("R4", 1300, -200, -200, 64, -1);
    tWindow("R4", 2047, -2048, 0, 64, -1);
    tWindow("R5", 1000, 0, -1000, 64, 4);
    tWindow("R2", 1000, -500, -500, 32, -1);
    tPeriod(0);
    tPeriod(17);
    tLatch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule